// File: doc/BRIEF.md
# Multichannel Scene Partition and Complex Sum

This block spreads the point targets of a radar scene across a set of identical accumulation channels, lets them build partial impulse responses in parallel, and then merges them into one response. Targets arrive one per cycle on a loading port. Each target has a range bin and a complex reflection value. They are dealt out to the channels in rotation. Each channel owns a two-bank input store and a per-bin complex accumulator store. While one bank is being computed, the other bank is filled with the scene for the following pulse period.

A pulse-period strobe swaps the banks and starts every channel. Each channel first zeroes its accumulator store. It then adds every target held in its compute bank into the bin named by that target. Once every channel reports completion, a reduction stage walks the bins from zero upward. At each bin it reads that bin from every channel, sums the complex values through an adder tree that is wide enough to never wrap, and presents the result on a valid/ready output stream. The last bin of the stream is marked.

Top module: `scene_sum_top`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` and `out_last` are low.
- R2: Counting from zero after each accepted period strobe, loaded target k goes to channel k mod NCH. A channel holds at most DEPTH targets per period, so targets with k ≥ NCH·DEPTH are dropped and never reach the sum.
- R3: Targets loaded after an accepted period strobe are summed only in the period started by the next accepted strobe. Loading while channels compute or while the stream is output does not change the current stream.
- R4: `out_valid` stays low after an accepted strobe until every channel has finished its clear pass (NBINS cycles) and its accumulation pass.
- R5: Each period emits exactly NBINS transfers with `out_bin` = 0, 1, …, NBINS-1 in order. `out_last` is high exactly on bin NBINS-1, and `out_valid` drops after that transfer.
- R6: `out_re`/`out_im` at bin b are the exact two's-complement sums of the real/imaginary parts of all kept targets of that period with bin b. The output width grows so that NCH·DEPTH full-scale values cannot overflow.
- R7: While `out_valid` is high and `out_ready` low, `out_valid`, `out_bin`, `out_re` and `out_im` hold their values.
- R8: A period strobe that arrives while channels compute or the stream is pending is ignored: no new period starts and the bank roles do not swap.
- R9: A period with no loaded targets yields a stream of all-zero bins, with nothing carried over from the previous period.
- R10: A target presented in the same cycle as an accepted strobe becomes target 0 (channel 0) of the newly loading bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 1 | Pulse-period strobe; accepted only when idle |
| tgt_valid | input | 1 | A target is presented this cycle |
| tgt_bin | input | $clog2(NBINS) | Range bin of the target |
| tgt_re | input | DW | Signed real part of the target value |
| tgt_im | input | DW | Signed imaginary part of the target value |
| out_valid | output | 1 | Combined bin available |
| out_ready | input | 1 | Consumer accepts the combined bin |
| out_bin | output | $clog2(NBINS) | Bin index of the combined value |
| out_re | output | DW+$clog2(DEPTH+1)+$clog2(NCH) | Signed real sum over all channels |
| out_im | output | DW+$clog2(DEPTH+1)+$clog2(NCH) | Signed imaginary sum over all channels |
| out_last | output | 1 | Marks the final bin of a period |

## Verification
The sum is tried with several scene patterns. A handful of targets on distinct bins shows that the per-bin routing is right. A full scene of NCH·DEPTH targets with a stride that makes bins collide shows that partials from different channels are added. A scene two targets over capacity shows the drop rule. A full scene of full-scale values on one bin shows that the width growth is sufficient. An empty period that follows a loaded one shows that the accumulators are cleared. Each following scene is loaded while the current one is computing, so any mixing of the two banks shows up as wrong sums. Back-pressure patterns (always ready, alternating, two-of-three) separate correct holding of the output from premature advancing. A strobe that arrives during the stream, and a target that coincides with the strobe, cover the bank-swap rules.

// File: rtl/scene_pkg.sv
package scene_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_RED  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_CLR  = 2'd1,
        CH_ACC  = 2'd2,
        CH_DONE = 2'd3
    } chan_st_e;

endpackage

// File: rtl/scene_chan.sv
// One accumulation channel: two-bank target store plus per-bin complex accumulators.
module scene_chan
    import scene_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NBINS = 16,
    parameter int DEPTH = 4,
    parameter int ACC_W = 11,
    localparam int BIN_W = $clog2(NBINS),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PW    = (BIN_W > CNT_W) ? BIN_W : CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    cbank_i,
    input  logic                    wr_en_i,
    input  logic                    wr_bank_i,
    input  logic [BIN_W-1:0]        wr_bin_i,
    input  logic signed [DW-1:0]    wr_re_i,
    input  logic signed [DW-1:0]    wr_im_i,
    output logic                    done_o,
    input  logic [BIN_W-1:0]        rd_addr_i,
    output logic signed [ACC_W-1:0] rd_re_o,
    output logic signed [ACC_W-1:0] rd_im_o
);

    typedef struct packed {
        chan_st_e         st;
        logic             cbank;
        logic [PW-1:0]    ptr;
        logic [CNT_W-1:0] cnt0;
        logic [CNT_W-1:0] cnt1;
    } chan_reg_t;

    chan_reg_t st_d, st_q;

    logic [BIN_W-1:0]        in_bin [2][DEPTH];
    logic signed [DW-1:0]    in_re  [2][DEPTH];
    logic signed [DW-1:0]    in_im  [2][DEPTH];
    logic signed [ACC_W-1:0] acc_re [NBINS];
    logic signed [ACC_W-1:0] acc_im [NBINS];

    logic                    in_we;
    logic [IDX_W-1:0]        in_addr;
    logic                    clr_en;
    logic                    acc_en;
    logic [CNT_W-1:0]        wcnt;
    logic [CNT_W-1:0]        ccnt;
    logic [BIN_W-1:0]        e_bin;
    logic signed [DW-1:0]    e_re;
    logic signed [DW-1:0]    e_im;

    assign e_bin = in_bin[st_q.cbank][st_q.ptr[IDX_W-1:0]];
    assign e_re  = in_re[st_q.cbank][st_q.ptr[IDX_W-1:0]];
    assign e_im  = in_im[st_q.cbank][st_q.ptr[IDX_W-1:0]];

    always_comb begin
        st_d    = st_q;
        in_we   = 1'b0;
        in_addr = '0;
        clr_en  = 1'b0;
        acc_en  = 1'b0;
        ccnt    = st_q.cbank ? st_q.cnt1 : st_q.cnt0;

        // loading side: the bank being filled restarts at slot 0 on a start
        wcnt = wr_bank_i ? st_q.cnt1 : st_q.cnt0;
        if (start_i) begin
            wcnt = '0;
        end
        if (wr_bank_i) st_d.cnt1 = wcnt;
        else           st_d.cnt0 = wcnt;
        if (wr_en_i && (wcnt < CNT_W'(DEPTH))) begin
            in_we   = 1'b1;
            in_addr = wcnt[IDX_W-1:0];
            if (wr_bank_i) st_d.cnt1 = wcnt + 1'b1;
            else           st_d.cnt0 = wcnt + 1'b1;
        end

        // compute side
        if (start_i) begin
            st_d.st    = CH_CLR;
            st_d.cbank = cbank_i;
            st_d.ptr   = '0;
        end else begin
            case (st_q.st)
                CH_CLR: begin
                    clr_en = 1'b1;
                    if (st_q.ptr == PW'(NBINS - 1)) begin
                        st_d.st  = CH_ACC;
                        st_d.ptr = '0;
                    end else begin
                        st_d.ptr = st_q.ptr + 1'b1;
                    end
                end
                CH_ACC: begin
                    if (st_q.ptr == PW'(ccnt)) begin
                        st_d.st = CH_DONE;
                    end else begin
                        acc_en   = 1'b1;
                        st_d.ptr = st_q.ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: CH_IDLE, cbank: 1'b0, ptr: '0, cnt0: '0, cnt1: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (in_we) begin
            in_bin[wr_bank_i][in_addr] <= wr_bin_i;
            in_re[wr_bank_i][in_addr]  <= wr_re_i;
            in_im[wr_bank_i][in_addr]  <= wr_im_i;
        end
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            acc_re[st_q.ptr[BIN_W-1:0]] <= '0;
            acc_im[st_q.ptr[BIN_W-1:0]] <= '0;
        end else if (acc_en) begin
            acc_re[e_bin] <= acc_re[e_bin] + ACC_W'(e_re);
            acc_im[e_bin] <= acc_im[e_bin] + ACC_W'(e_im);
        end
    end

    assign done_o  = (st_q.st == CH_DONE);
    assign rd_re_o = acc_re[rd_addr_i];
    assign rd_im_o = acc_im[rd_addr_i];

endmodule

// File: rtl/scene_sum_tree.sv
// Balanced signed adder tree; output carries one growth bit per level.
module scene_sum_tree #(
    parameter int N  = 12,
    parameter int IW = 11,
    localparam int LV = $clog2(N),
    localparam int P  = 1 << LV,
    localparam int OW = IW + LV
) (
    input  logic [N*IW-1:0]       in_flat,
    output logic signed [OW-1:0]  sum_o
);

    logic signed [OW-1:0] node [2*P-1];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_used
            assign node[P-1+i] = OW'($signed(in_flat[i*IW +: IW]));
        end else begin : g_pad
            assign node[P-1+i] = '0;
        end
    end

    for (genvar j = 0; j < P - 1; j++) begin : g_node
        assign node[j] = node[2*j+1] + node[2*j+2];
    end

    assign sum_o = node[0];

endmodule

// File: rtl/scene_sum_top.sv
module scene_sum_top
    import scene_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int NBINS = 16,
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int BIN_W = $clog2(NBINS),
    localparam int RR_W  = $clog2(NCH),
    localparam int ACC_W = DW + $clog2(DEPTH + 1),
    localparam int SUM_W = ACC_W + $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    period_start,
    input  logic                    tgt_valid,
    input  logic [BIN_W-1:0]        tgt_bin,
    input  logic signed [DW-1:0]    tgt_re,
    input  logic signed [DW-1:0]    tgt_im,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [BIN_W-1:0]        out_bin,
    output logic signed [SUM_W-1:0] out_re,
    output logic signed [SUM_W-1:0] out_im,
    output logic                    out_last
);

    typedef struct packed {
        phase_e           phase;
        logic             load_bank;
        logic [RR_W-1:0]  rr;
        logic [BIN_W-1:0] bin;
    } top_reg_t;

    top_reg_t st_d, st_q;

    logic                 is_idle;
    logic                 start_acc;
    logic                 wr_bank;
    logic [NCH-1:0]       chan_done;
    logic [NCH-1:0]       chan_wr;
    logic [NCH*ACC_W-1:0] re_flat;
    logic [NCH*ACC_W-1:0] im_flat;

    assign is_idle   = (st_q.phase == PH_IDLE);
    assign start_acc = period_start && is_idle;
    assign wr_bank   = start_acc ? ~st_q.load_bank : st_q.load_bank;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [ACC_W-1:0] ch_re;
        logic signed [ACC_W-1:0] ch_im;

        assign chan_wr[c] = tgt_valid &&
                            (start_acc ? (c == 0) : (st_q.rr == RR_W'(c)));

        scene_chan #(
            .DW    (DW),
            .NBINS (NBINS),
            .DEPTH (DEPTH),
            .ACC_W (ACC_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_acc),
            .cbank_i   (st_q.load_bank),
            .wr_en_i   (chan_wr[c]),
            .wr_bank_i (wr_bank),
            .wr_bin_i  (tgt_bin),
            .wr_re_i   (tgt_re),
            .wr_im_i   (tgt_im),
            .done_o    (chan_done[c]),
            .rd_addr_i (st_q.bin),
            .rd_re_o   (ch_re),
            .rd_im_o   (ch_im)
        );

        assign re_flat[c*ACC_W +: ACC_W] = ch_re;
        assign im_flat[c*ACC_W +: ACC_W] = ch_im;
    end

    scene_sum_tree #(.N(NCH), .IW(ACC_W)) u_tree_re (
        .in_flat (re_flat),
        .sum_o   (out_re)
    );

    scene_sum_tree #(.N(NCH), .IW(ACC_W)) u_tree_im (
        .in_flat (im_flat),
        .sum_o   (out_im)
    );

    always_comb begin
        st_d = st_q;

        if (start_acc) begin
            st_d.load_bank = ~st_q.load_bank;
            st_d.rr        = tgt_valid ? RR_W'(1) : '0;
            st_d.phase     = PH_RUN;
            st_d.bin       = '0;
        end else if (tgt_valid) begin
            st_d.rr = (st_q.rr == RR_W'(NCH - 1)) ? '0 : st_q.rr + 1'b1;
        end

        case (st_q.phase)
            PH_RUN: begin
                if (&chan_done) begin
                    st_d.phase = PH_RED;
                end
            end
            PH_RED: begin
                if (out_ready) begin
                    if (st_q.bin == BIN_W'(NBINS - 1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.bin   = '0;
                    end else begin
                        st_d.bin = st_q.bin + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, load_bank: 1'b0, rr: '0, bin: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = (st_q.phase == PH_RED);
    assign out_bin   = st_q.bin;
    assign out_last  = out_valid && (st_q.bin == BIN_W'(NBINS - 1));

endmodule

// File: rtl/scene_sum_chk.sv
module scene_sum_chk #(
    parameter int NCH   = 12,
    parameter int NBINS = 16,
    parameter int SUM_W = 15,
    localparam int BIN_W = $clog2(NBINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_start,
    input logic             is_idle,
    input logic             load_bank,
    input logic [NCH-1:0]   chan_done,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [BIN_W-1:0] out_bin,
    input logic [SUM_W-1:0] out_re,
    input logic [SUM_W-1:0] out_im
);

    // R4
    all_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (&chan_done));

    // R5
    first_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_bin == '0));

    // R5
    bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            (out_valid && out_bin == BIN_W'($past(out_bin) + 1'b1)));

    // R5
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_bin == BIN_W'(NBINS - 1)));

    // R5
    stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bin) && $stable(out_re) && $stable(out_im)));

    // R3
    bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && is_idle) |=> (load_bank != $past(load_bank)));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !is_idle) |=> $stable(load_bank));

endmodule

bind scene_sum_top scene_sum_chk #(
    .NCH   (NCH),
    .NBINS (NBINS),
    .SUM_W (SUM_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .is_idle      (is_idle),
    .load_bank    (st_q.load_bank),
    .chan_done    (chan_done),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_last     (out_last),
    .out_bin      (out_bin),
    .out_re       (out_re),
    .out_im       (out_im)
);

// File: tb/sim_scene_sum_top.sv
module sim_scene_sum_top;

    localparam int NCH   = 12;
    localparam int NBINS = 16;
    localparam int DEPTH = 4;
    localparam int DW    = 8;
    localparam int BIN_W = 4;
    localparam int SUM_W = 15;
    localparam int CAP   = NCH * DEPTH;

    // stimulus table: target count, bin stride, re/im multipliers, full-scale flag, ready mode
    localparam int NPAT = 6;
    localparam int P_N   [NPAT] = '{12, 48, 50, 0, 48, 7};
    localparam int P_STR [NPAT] = '{1, 5, 3, 0, 0, 2};
    localparam int P_RM  [NPAT] = '{7, 13, 9, 1, 0, 5};
    localparam int P_IM  [NPAT] = '{11, 3, 17, 1, 0, 19};
    localparam int P_EXT [NPAT] = '{0, 0, 0, 0, 1, 0};
    localparam int P_RDY [NPAT] = '{0, 1, 0, 0, 2, 1};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst_n;
    logic                    period_start;
    logic                    tgt_valid;
    logic [BIN_W-1:0]        tgt_bin;
    logic signed [DW-1:0]    tgt_re;
    logic signed [DW-1:0]    tgt_im;
    logic                    out_valid;
    logic                    out_ready;
    logic [BIN_W-1:0]        out_bin;
    logic signed [SUM_W-1:0] out_re;
    logic signed [SUM_W-1:0] out_im;
    logic                    out_last;

    scene_sum_top #(.NCH(NCH), .NBINS(NBINS), .DEPTH(DEPTH), .DW(DW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .tgt_valid    (tgt_valid),
        .tgt_bin      (tgt_bin),
        .tgt_re       (tgt_re),
        .tgt_im       (tgt_im),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_bin      (out_bin),
        .out_re       (out_re),
        .out_im       (out_im),
        .out_last     (out_last)
    );

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;
    bit finished = 1'b0;

    int exp_nx_re [NBINS];
    int exp_nx_im [NBINS];
    int exp_re    [NBINS];
    int exp_im    [NBINS];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc_total);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // R2: round-robin with NCH*DEPTH capacity; extra targets are left out of the model
    task automatic load_pat(input int p);
        for (int k = 0; k < P_N[p]; k++) begin
            int b;
            int re;
            int im;
            b  = (k * P_STR[p] + p) % NBINS;
            re = (P_EXT[p] != 0) ? -128 : ((k * P_RM[p] + p * 3) % 200) - 100;
            im = (P_EXT[p] != 0) ? 127  : ((k * P_IM[p] + 1) % 190) - 95;
            @(negedge clk);
            tgt_valid = 1'b1;
            tgt_bin   = BIN_W'(b);
            tgt_re    = 8'(re);
            tgt_im    = 8'(im);
            if (k < CAP) begin
                exp_nx_re[b] += re;
                exp_nx_im[b] += im;
            end
        end
        @(negedge clk);
        tgt_valid = 1'b0;
    endtask

    task automatic fire();
        bit quiet;
        @(negedge clk);
        period_start = 1'b1;
        for (int b = 0; b < NBINS; b++) begin
            exp_re[b] = exp_nx_re[b];
            exp_im[b] = exp_nx_im[b];
            exp_nx_re[b] = 0;
            exp_nx_im[b] = 0;
        end
        @(negedge clk);
        period_start = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < NBINS; i++) begin
            if (out_valid) quiet = 1'b0;
            @(negedge clk);
        end
        // R4: no output during the clear pass of the channels
        chk(quiet, "R4 early out_valid", int'(!quiet), 0);
    endtask

    task automatic collect(input int mode, input bit poke, input string tag);
        int idx = 0;
        int cyc = 0;
        bit stalled = 1'b0;
        bit poked = 1'b0;
        int pb = 0;
        int pre = 0;
        int pim = 0;
        while (idx < NBINS && cyc < 3000) begin
            bit rdy;
            @(negedge clk);
            cyc++;
            period_start = 1'b0;
            if (stalled) begin
                // R7
                chk(out_valid && int'(out_bin) == pb && int'(out_re) == pre && int'(out_im) == pim,
                    "R7 hold under stall", int'(out_re), pre);
            end
            stalled = 1'b0;
            if (out_valid) begin
                case (mode)
                    0: rdy = 1'b1;
                    1: rdy = (cyc % 2) == 1;
                    default: rdy = (cyc % 3) != 0;
                endcase
                out_ready = rdy;
                if (poke && !rdy && !poked) begin
                    period_start = 1'b1;
                    poked = 1'b1;
                end
                if (rdy) begin
                    chk(int'(out_bin) == idx, {tag, " R5 bin order"}, int'(out_bin), idx);
                    chk(out_last == (idx == NBINS - 1), {tag, " R5 last flag"}, int'(out_last),
                        int'(idx == NBINS - 1));
                    chk(int'(out_re) == exp_re[idx], {tag, " R6 real sum"}, int'(out_re), exp_re[idx]);
                    chk(int'(out_im) == exp_im[idx], {tag, " R6 imag sum"}, int'(out_im), exp_im[idx]);
                    idx++;
                end else begin
                    stalled = 1'b1;
                    pb  = int'(out_bin);
                    pre = int'(out_re);
                    pim = int'(out_im);
                end
            end else begin
                out_ready = 1'b0;
            end
        end
        chk(idx == NBINS, {tag, " R5 transfer count"}, idx, NBINS);
        @(negedge clk);
        out_ready    = 1'b0;
        period_start = 1'b0;
        chk(!out_valid, {tag, " R5 stream end"}, int'(out_valid), 0);
    endtask

    initial begin
        rst_n        = 1'b0;
        period_start = 1'b0;
        tgt_valid    = 1'b0;
        tgt_bin      = '0;
        tgt_re       = '0;
        tgt_im       = '0;
        out_ready    = 1'b0;
        for (int b = 0; b < NBINS; b++) begin
            exp_nx_re[b] = 0;
            exp_nx_im[b] = 0;
            exp_re[b]    = 0;
            exp_im[b]    = 0;
        end

        repeat (3) @(negedge clk);
        // R1
        chk(!out_valid && !out_last, "R1 in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_last, "R1 after reset", int'(out_valid), 0);

        // table walk; the next scene is always loaded while the current one computes (R3)
        load_pat(0);
        for (int p = 0; p < NPAT; p++) begin
            string tag;
            case (p)
                1: tag = "R3";
                2: tag = "R2";
                3: tag = "R9";
                4: tag = "R6 full-scale";
                default: tag = "R6";
            endcase
            fire();
            if (p + 1 < NPAT) load_pat(p + 1);
            collect(P_RDY[p], p == 1, tag);
            if (p == 1) begin
                bit stray = 1'b0;
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    if (out_valid) stray = 1'b1;
                end
                // R8: the strobe sent during the stream started nothing
                chk(!stray, "R8 busy strobe ignored", int'(stray), 0);
            end
        end

        // R10: target coinciding with an accepted strobe lands in the new bank
        for (int b = 0; b < NBINS; b++) begin
            exp_re[b] = 0;
            exp_im[b] = 0;
        end
        @(negedge clk);
        period_start = 1'b1;
        tgt_valid    = 1'b1;
        tgt_bin      = 4'd3;
        tgt_re       = 8'sd5;
        tgt_im       = -8'sd2;
        @(negedge clk);
        period_start = 1'b0;
        tgt_valid    = 1'b0;
        collect(0, 1'b0, "R10 empty period");
        exp_nx_re[3] = 5;
        exp_nx_im[3] = -2;
        fire();
        collect(0, 1'b0, "R10 coincident target");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule